// File: doc/BRIEF.md
# Multiplexed Address/Data Static Memory Port

This block is the device-side front end of a static memory whose address and data share one 16-bit bus. Each access has two phases. First the host pulls chip enable and an address strobe low and presents the address, with the low 16 bits on the shared bus and the upper bits on separate address pins. The block captures that address and keeps it once the strobe returns high. In the second phase the same bus pins carry data. For a read, the block drives the bus one byte lane at a time, with each lane gated by its own active-low lane select. For a write, the block takes data from the bus and stores it when the write window closes.

Five control pins select the mode. These are chip enable, output enable, write enable, the address strobe and the pair of lane selects. The modes are deselected, output disabled, address input, read and write. A small register-file array of parameterized depth stands in for the storage cells, so that the interface can be exercised against a host model. All pins are sampled on the block clock. The bidirectional bus is split into an input, an output and a per-lane drive enable; the pad ring joins these into a tri-state bus. A lane with its drive enable low is high impedance.

Top module: `muxbus_sram_port`

## Requirements
- R1: When chip enable is high, both drive enable bits are 0, whatever the other control pins are.
- R2: When chip enable is low, the strobe is low and write enable is high, the block takes the address at each clock edge. Bus bits 15:0 form address bits 15:0, and the upper address pins form bits 17:16.
- R3: After the strobe rises, the latched address keeps the value taken at the last edge with the strobe low, until the next address-input phase. Bus activity in between has no effect on it.
- R4: A read drives lanes when chip enable and output enable are low and write enable and the strobe are high. Drive enable bit 0 (bus bits 7:0) is 1 only when lane select bit 0 is low. Drive enable bit 1 (bus bits 15:8) is 1 only when lane select bit 1 is low. The driven lanes carry the stored word at the latched address within the same cycle.
- R5: When output enable is high, or when both lane select bits are high, neither lane is driven.
- R6: The write window is open while chip enable and write enable are both low. The store takes place at the first clock edge at which either of them is seen high. It uses the bus value and the lane selects taken at the last edge inside the window. Only lanes whose select was low change; the other lane keeps its contents.
- R7: A write or read with both lane selects low covers the full 16-bit word.
- R8: The array depth is a parameter (64 by default). A latched address maps to the array word at address modulo depth, so address 0x30041 and address 1 name the same word.
- R9: When write enable and output enable are both low, no lane is driven, and the write still takes place.
- R10: While reset is applied, no lane is driven and no write is stored. The latched address returns to 0, and no write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; all pins are sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| chip_en_n | input | 1 | Active-low chip enable |
| out_en_n | input | 1 | Active-low output enable |
| wr_en_n | input | 1 | Active-low write enable |
| lane_sel_n | input | 2 | Active-low byte lane selects; bit 0 is bus bits 7:0, bit 1 is bus bits 15:8 |
| addr_stb_n | input | 1 | Active-low address strobe |
| addr_hi | input | 2 | Upper address bits 17:16 |
| bus_in | input | 16 | Shared bus as seen from the pads |
| bus_out | output | 16 | Read data toward the pads; zero on undriven lanes |
| bus_drv | output | 2 | Per-lane pad drive enable; a 0 lane is high impedance |

## Verification
The lane drive enables and the read data follow the control pins and the latched address in the same cycle, with no register in between. The bench therefore changes pins on the falling clock edge and samples the outputs one nanosecond later, before the next rising edge. An address is latched at the first rising edge after the strobe goes low. A write is stored at the first rising edge after the window closes. For this reason every read-back begins one falling edge after the pin that closed the window, so one rising edge has passed. The ignored cases are checked at the ports: the bench reads back the word that the ignored stimulus could have changed. These cases are writes under reset, writes with no lane selected, and bus traffic after the strobe rises.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

  typedef enum logic [2:0] {
    MODE_OFF   = 3'd0,
    MODE_QUIET = 3'd1,
    MODE_ADDR  = 3'd2,
    MODE_READ  = 3'd3,
    MODE_WRITE = 3'd4
  } bus_mode_e;

  localparam int unsigned LANE_BITS = 8;

endpackage

// File: rtl/muxbus_rst_sync.sv
module muxbus_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ok
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_ok = sync_q[1];

endmodule

// File: rtl/muxbus_mode_dec.sv
module muxbus_mode_dec
  import muxbus_pkg::*;
#(
  parameter int unsigned LANES = 2
) (
  input  logic             chip_en_n,
  input  logic             out_en_n,
  input  logic             wr_en_n,
  input  logic [LANES-1:0] lane_sel_n,
  input  logic             addr_stb_n,
  output bus_mode_e        mode,
  output logic [LANES-1:0] lanes
);

  logic any_lane;

  always_comb begin
    lanes    = ~lane_sel_n;
    any_lane = |lanes;
    if (chip_en_n) begin
      mode = MODE_OFF;
    end else if (!wr_en_n) begin
      // write wins over output enable: bus stays an input
      mode = MODE_WRITE;
    end else if (!addr_stb_n) begin
      mode = MODE_ADDR;
    end else if (!out_en_n && any_lane) begin
      mode = MODE_READ;
    end else begin
      mode = MODE_QUIET;
    end
  end

endmodule

// File: rtl/muxbus_addr_latch.sv
module muxbus_addr_latch #(
  parameter int unsigned ADDR_W = 18
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_en,
  input  logic [ADDR_W-1:0] cap_addr,
  output logic [ADDR_W-1:0] lat_addr
);

  logic [ADDR_W-1:0] lat_d;
  logic [ADDR_W-1:0] lat_q;

  always_comb begin
    lat_d = lat_q;
    if (cap_en) begin
      lat_d = cap_addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat_q <= '0;
    end else begin
      lat_q <= lat_d;
    end
  end

  assign lat_addr = lat_q;

endmodule

// File: rtl/muxbus_wr_ctrl.sv
module muxbus_wr_ctrl #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              win,
  input  logic [LANES-1:0]  lanes,
  input  logic [DATA_W-1:0] bus_in,
  output logic [LANES-1:0]  commit_lanes,
  output logic [DATA_W-1:0] commit_data
);

  logic              win_q;
  logic [LANES-1:0]  lanes_d;
  logic [LANES-1:0]  lanes_q;
  logic [DATA_W-1:0] data_d;
  logic [DATA_W-1:0] data_q;
  logic              win_end;

  always_comb begin
    lanes_d = lanes_q;
    data_d  = data_q;
    if (win) begin
      lanes_d = lanes;
      data_d  = bus_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= 1'b0;
    end else begin
      win_q <= win;
    end
  end

  always_ff @(posedge clk) begin
    if (win) begin
      lanes_q <= lanes_d;
      data_q  <= data_d;
    end
  end

  assign win_end      = win_q && !win;
  assign commit_lanes = win_end ? lanes_q : '0;
  assign commit_data  = data_q;

endmodule

// File: rtl/muxbus_store.sv
module muxbus_store
  import muxbus_pkg::*;
#(
  parameter int unsigned LANES  = 2,
  parameter int unsigned ADDR_W = 18,
  parameter int unsigned DEPTH  = 64
) (
  input  logic                        clk,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [LANES-1:0]            wr_lanes,
  input  logic [LANES*LANE_BITS-1:0]  wr_data,
  output logic [LANES*LANE_BITS-1:0]  rd_data
);

  localparam int unsigned IDX_W = $clog2(DEPTH);
  localparam bit          POW2  = (DEPTH == (1 << IDX_W));

  logic [IDX_W-1:0] idx;
  logic             unused_hi;

  generate
    if (POW2) begin : g_slice
      assign idx       = addr[IDX_W-1:0];
      assign unused_hi = ^addr[ADDR_W-1:IDX_W];
    end else begin : g_mod
      localparam logic [ADDR_W-1:0] DEPTH_A = ADDR_W'(DEPTH);
      logic [ADDR_W-1:0] idx_full;
      assign idx_full  = addr % DEPTH_A;
      assign idx       = idx_full[IDX_W-1:0];
      assign unused_hi = ^idx_full[ADDR_W-1:IDX_W];
    end
  endgenerate

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_lane
      logic [LANE_BITS-1:0] cells [DEPTH];
      always_ff @(posedge clk) begin
        if (wr_lanes[l]) begin
          cells[idx] <= wr_data[l*LANE_BITS +: LANE_BITS];
        end
      end
      assign rd_data[l*LANE_BITS +: LANE_BITS] = cells[idx];
    end
  endgenerate

endmodule

// File: rtl/muxbus_sram_port.sv
module muxbus_sram_port
  import muxbus_pkg::*;
#(
  parameter int unsigned DATA_W = 16,
  parameter int unsigned HI_W   = 2,
  parameter int unsigned DEPTH  = 64
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      chip_en_n,
  input  logic                      out_en_n,
  input  logic                      wr_en_n,
  input  logic [DATA_W/8-1:0]       lane_sel_n,
  input  logic                      addr_stb_n,
  input  logic [HI_W-1:0]           addr_hi,
  input  logic [DATA_W-1:0]         bus_in,
  output logic [DATA_W-1:0]         bus_out,
  output logic [DATA_W/8-1:0]       bus_drv
);

  localparam int unsigned LANES  = DATA_W / LANE_BITS;
  localparam int unsigned ADDR_W = DATA_W + HI_W;

  logic              rst_ok;
  bus_mode_e         mode;
  logic [LANES-1:0]  lanes;
  logic              cap_en;
  logic              win;
  logic              rd_on;
  logic [ADDR_W-1:0] lat_addr;
  logic [LANES-1:0]  commit_lanes;
  logic [DATA_W-1:0] commit_data;
  logic [DATA_W-1:0] rd_data;

  muxbus_rst_sync i_rst_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_ok (rst_ok)
  );

  muxbus_mode_dec #(.LANES(LANES)) i_mode_dec (
    .chip_en_n  (chip_en_n),
    .out_en_n   (out_en_n),
    .wr_en_n    (wr_en_n),
    .lane_sel_n (lane_sel_n),
    .addr_stb_n (addr_stb_n),
    .mode       (mode),
    .lanes      (lanes)
  );

  assign cap_en = (mode == MODE_ADDR);
  assign win    = (mode == MODE_WRITE) && rst_ok;
  assign rd_on  = (mode == MODE_READ) && rst_ok;

  muxbus_addr_latch #(.ADDR_W(ADDR_W)) i_addr_latch (
    .clk      (clk),
    .rst_n    (rst_ok),
    .cap_en   (cap_en),
    .cap_addr ({addr_hi, bus_in}),
    .lat_addr (lat_addr)
  );

  muxbus_wr_ctrl #(.LANES(LANES), .DATA_W(DATA_W)) i_wr_ctrl (
    .clk          (clk),
    .rst_n        (rst_ok),
    .win          (win),
    .lanes        (lanes),
    .bus_in       (bus_in),
    .commit_lanes (commit_lanes),
    .commit_data  (commit_data)
  );

  muxbus_store #(.LANES(LANES), .ADDR_W(ADDR_W), .DEPTH(DEPTH)) i_store (
    .clk      (clk),
    .addr     (lat_addr),
    .wr_lanes (commit_lanes),
    .wr_data  (commit_data),
    .rd_data  (rd_data)
  );

  generate
    for (genvar l = 0; l < LANES; l++) begin : g_out
      assign bus_drv[l] = rd_on && lanes[l];
      assign bus_out[l*LANE_BITS +: LANE_BITS] =
        bus_drv[l] ? rd_data[l*LANE_BITS +: LANE_BITS] : '0;
    end
  endgenerate

endmodule

// File: rtl/muxbus_sram_port_chk.sv
module muxbus_sram_port_chk #(
  parameter int unsigned LANES  = 2,
  parameter int unsigned DATA_W = 16,
  parameter int unsigned HI_W   = 2,
  parameter int unsigned ADDR_W = 18
) (
  input logic              clk,
  input logic              rst_ok,
  input logic              chip_en_n,
  input logic              out_en_n,
  input logic              wr_en_n,
  input logic [LANES-1:0]  lane_sel_n,
  input logic              addr_stb_n,
  input logic [HI_W-1:0]   addr_hi,
  input logic [DATA_W-1:0] bus_in,
  input logic [LANES-1:0]  bus_drv,
  input logic [ADDR_W-1:0] lat_addr
);

  AST_OFF_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_ok)
    chip_en_n |-> (bus_drv == '0)); // R1

  AST_ADDR_TAKEN: assert property (@(posedge clk) disable iff (!rst_ok)
    (!chip_en_n && !addr_stb_n && wr_en_n) |=> (lat_addr == $past({addr_hi, bus_in}))); // R2

  AST_ADDR_KEPT: assert property (@(posedge clk) disable iff (!rst_ok)
    (chip_en_n || addr_stb_n || !wr_en_n) |=> $stable(lat_addr)); // R3

  AST_LANE_GATED: assert property (@(posedge clk) disable iff (!rst_ok)
    ((bus_drv & lane_sel_n) == '0)); // R4

  AST_STB_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_ok)
    !addr_stb_n |-> (bus_drv == '0)); // R4

  AST_OE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_ok)
    out_en_n |-> (bus_drv == '0)); // R5

  AST_WRITE_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_ok)
    !wr_en_n |-> (bus_drv == '0)); // R9

endmodule

bind muxbus_sram_port muxbus_sram_port_chk #(
  .LANES(LANES), .DATA_W(DATA_W), .HI_W(HI_W), .ADDR_W(ADDR_W)
) i_chk (
  .clk        (clk),
  .rst_ok     (rst_ok),
  .chip_en_n  (chip_en_n),
  .out_en_n   (out_en_n),
  .wr_en_n    (wr_en_n),
  .lane_sel_n (lane_sel_n),
  .addr_stb_n (addr_stb_n),
  .addr_hi    (addr_hi),
  .bus_in     (bus_in),
  .bus_drv    (bus_drv),
  .lat_addr   (lat_addr)
);

// File: tb/test_muxbus_sram_port.sv
`timescale 1ns/1ps
module test_muxbus_sram_port;

  logic        clk;
  logic        rst_n;
  logic        chip_en_n;
  logic        out_en_n;
  logic        wr_en_n;
  logic [1:0]  lane_sel_n;
  logic        addr_stb_n;
  logic [1:0]  addr_hi;
  logic [15:0] bus_in;
  logic [15:0] bus_out;
  logic [1:0]  bus_drv;

  int n_cmp;
  int n_bad;
  bit done;

  muxbus_sram_port i_muxbus_sram_port (
    .clk(clk), .rst_n(rst_n), .chip_en_n(chip_en_n), .out_en_n(out_en_n),
    .wr_en_n(wr_en_n), .lane_sel_n(lane_sel_n), .addr_stb_n(addr_stb_n),
    .addr_hi(addr_hi), .bus_in(bus_in), .bus_out(bus_out), .bus_drv(bus_drv)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic go_idle();
    @(negedge clk);
    chip_en_n = 1'b1; out_en_n = 1'b1; wr_en_n = 1'b1;
    lane_sel_n = 2'b11; addr_stb_n = 1'b1; bus_in = 16'h0;
  endtask

  task automatic put_addr(input logic [17:0] a);
    @(negedge clk);
    chip_en_n = 1'b0; out_en_n = 1'b1; wr_en_n = 1'b1; lane_sel_n = 2'b11;
    addr_stb_n = 1'b0; bus_in = a[15:0]; addr_hi = a[17:16];
    @(negedge clk);
    addr_stb_n = 1'b1; bus_in = 16'hDEAD; addr_hi = 2'b00;
  endtask

  task automatic put_word(input logic [17:0] a, input logic [15:0] d, input logic [1:0] sel);
    put_addr(a);
    @(negedge clk);
    wr_en_n = 1'b0; lane_sel_n = sel; bus_in = d;
    @(negedge clk);
    wr_en_n = 1'b1; bus_in = ~d;
    @(negedge clk);
    chip_en_n = 1'b1; lane_sel_n = 2'b11;
  endtask

  task automatic get_word(input string req, input logic [17:0] a, input logic [1:0] sel,
                          input logic [1:0] exp_drv, input logic [15:0] exp_data);
    logic [15:0] mask;
    put_addr(a);
    @(negedge clk);
    out_en_n = 1'b0; lane_sel_n = sel;
    #1;
    mask = {{8{exp_drv[1]}}, {8{exp_drv[0]}}};
    check({req, " lanes"}, 32'(bus_drv), 32'(exp_drv));
    if (exp_drv != 2'b00) check({req, " data"}, 32'(bus_out & mask), 32'(exp_data & mask));
    @(negedge clk);
    out_en_n = 1'b1; chip_en_n = 1'b1; lane_sel_n = 2'b11;
  endtask

  task automatic t_reset();
    rst_n = 1'b0; chip_en_n = 1'b0; out_en_n = 1'b0; wr_en_n = 1'b1;
    lane_sel_n = 2'b00; addr_stb_n = 1'b1; addr_hi = 2'b00; bus_in = 16'h0;
    repeat (3) @(negedge clk);
    #1 check("R10 no drive in reset", 32'(bus_drv), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    go_idle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_word();
    put_word(18'h00005, 16'hA5C3, 2'b00);
    get_word("R7 word readback", 18'h00005, 2'b00, 2'b11, 16'hA5C3);
  endtask

  task automatic t_reset_write();
    @(negedge clk);
    rst_n = 1'b0;
    put_word(18'h00005, 16'h1111, 2'b00);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    get_word("R10 write in reset ignored", 18'h00005, 2'b00, 2'b11, 16'hA5C3);
  endtask

  task automatic t_lanes();
    put_word(18'h00009, 16'h1234, 2'b00);
    put_word(18'h00009, 16'hFFAB, 2'b10);
    get_word("R6 lower lane only", 18'h00009, 2'b00, 2'b11, 16'h12AB);
    put_word(18'h00009, 16'hCDFF, 2'b01);
    get_word("R6 upper lane only", 18'h00009, 2'b00, 2'b11, 16'hCDAB);
    get_word("R4 upper read", 18'h00009, 2'b01, 2'b10, 16'hCDAB);
    get_word("R4 lower read", 18'h00009, 2'b10, 2'b01, 16'hCDAB);
    put_word(18'h00009, 16'h9999, 2'b11);
    get_word("R6 no lane no write", 18'h00009, 2'b00, 2'b11, 16'hCDAB);
  endtask

  task automatic t_quiet();
    put_addr(18'h00009);
    @(negedge clk);
    out_en_n = 1'b1; lane_sel_n = 2'b00;
    #1 check("R5 output enable high", 32'(bus_drv), 32'h0);
    @(negedge clk);
    out_en_n = 1'b0; lane_sel_n = 2'b11;
    #1 check("R5 no lane selected", 32'(bus_drv), 32'h0);
    @(negedge clk);
    chip_en_n = 1'b1; lane_sel_n = 2'b00;
    #1 check("R1 chip disabled", 32'(bus_drv), 32'h0);
    go_idle();
  endtask

  task automatic t_hold();
    put_addr(18'h00009);
    @(negedge clk);
    bus_in = 16'h0005; addr_hi = 2'b00;
    @(negedge clk);
    out_en_n = 1'b0; lane_sel_n = 2'b00;
    #1 check("R3 latch kept", 32'(bus_out), 32'hCDAB);
    go_idle();
  endtask

  task automatic t_wrap();
    put_word(18'h0000C, 16'h0C0C, 2'b00);
    get_word("R2 address from bus", 18'h0000C, 2'b00, 2'b11, 16'h0C0C);
    put_word(18'h3000A, 16'h7E7E, 2'b00);
    get_word("R8 upper pins wrap", 18'h0000A, 2'b00, 2'b11, 16'h7E7E);
    put_word(18'h00041, 16'h4141, 2'b00);
    get_word("R8 modulo depth", 18'h00001, 2'b00, 2'b11, 16'h4141);
  endtask

  task automatic t_prio();
    put_addr(18'h00014);
    @(negedge clk);
    out_en_n = 1'b0; wr_en_n = 1'b0; lane_sel_n = 2'b00; bus_in = 16'h55AA;
    #1 check("R9 no drive on write", 32'(bus_drv), 32'h0);
    @(negedge clk);
    out_en_n = 1'b1; wr_en_n = 1'b1; bus_in = 16'h0;
    go_idle();
    get_word("R9 write took place", 18'h00014, 2'b00, 2'b11, 16'h55AA);
  endtask

  task automatic t_cs_end();
    put_addr(18'h00015);
    @(negedge clk);
    wr_en_n = 1'b0; lane_sel_n = 2'b00; bus_in = 16'h0F0F;
    @(negedge clk);
    chip_en_n = 1'b1; bus_in = 16'hF0F0;
    @(negedge clk);
    wr_en_n = 1'b1;
    go_idle();
    get_word("R6 ended by chip enable", 18'h00015, 2'b00, 2'b11, 16'h0F0F);
  endtask

  task automatic t_last_sample();
    put_addr(18'h00016);
    @(negedge clk);
    wr_en_n = 1'b0; lane_sel_n = 2'b00; bus_in = 16'h1111;
    @(negedge clk);
    bus_in = 16'h2222;
    @(negedge clk);
    wr_en_n = 1'b1; bus_in = 16'h3333;
    go_idle();
    get_word("R6 last sample stored", 18'h00016, 2'b00, 2'b11, 16'h2222);
  endtask

  initial begin
    n_cmp = 0; n_bad = 0; done = 1'b0;
    t_reset();
    t_word();
    t_reset_write();
    t_lanes();
    t_quiet();
    t_hold();
    t_wrap();
    t_prio();
    t_cs_end();
    t_last_sample();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule